// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block receives stereo audio over a three-wire serial link made of a bit clock, a word clock and one data line. It runs in a system clock domain that is faster than the link. It synchronises all three wires, finds the rising edges of the bit clock, and rebuilds each left and right sample as a parallel word. When both channels of a frame have arrived, it presents the pair together with a single-cycle valid strobe.

A 16-bit control word is decoded at run time. It chooses one of four framings (I2S, left-justified, right-justified or DSP pulse-sync) and a sample length of 16, 20 or 24 bits. The same word carries a power-down bit and a two-bit de-emphasis selector, and both are passed out as status. Format codes this receiver does not implement, and the reserved width code, raise an error flag and suppress all output.

Top module: `audio_serial_rx`

## Requirements
- R1: With format field ctrlWord[7:5] = 000 (I2S), the left sample is taken while the word clock is low and the right sample while it is high. The MSB is the bit sampled on the second bit-clock rise after a word-clock change, and the following bits come MSB first.
- R2: With format field 011 (left-justified), the left sample is taken while the word clock is high. The MSB is the bit sampled on the first bit-clock rise after a word-clock change.
- R3: With format field 001 (right-justified), the left channel is the high half of the word clock. Each channel's sample is the last N bits before the next word-clock change, where N is the selected width, and earlier bits in the half are discarded.
- R4: With format field 010 (DSP), a one-bit-wide high pulse on the word clock opens the frame. The left MSB is sampled on the next bit-clock rise, and the right sample follows directly after the left LSB.
- R5: Width field ctrlWord[4:3] selects 00 = 24, 01 = 20 or 10 = 16 bits. Samples appear MSB-aligned on the 24-bit outputs, with the unused low bits zero.
- R6: sampleValid is a one-cycle pulse, raised once per frame after the right channel is captured, with leftOut and rightOut updated in that same cycle. Between pulses the outputs hold their values.
- R7: ctrlWord[2] = 1 drives powerDown high and holds sampleValid low and both sample outputs at zero.
- R8: Format codes 100 to 111 and width code 11 raise cfgError. While cfgError is high, no sample is output and both sample outputs are zero.
- R9: deemphSel follows ctrlWord[9:8] (00 none, 01 44.1 kHz, 10 32 kHz, 11 48 kHz).
- R10: ctrlWord[15:10] has no effect on the received samples.
- R11: After reset, sampleValid is low and both sample outputs are zero.
- R12: A change of the format or width field zeroes the sample outputs and restarts frame alignment, so no partial frame from the old setting is published.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 16 | Packed control word: format, width, power-down, de-emphasis |
| bclkIn | input | 1 | Serial bit clock, asynchronous |
| wclkIn | input | 1 | Word clock / frame sync, asynchronous |
| sdIn | input | 1 | Serial data, MSB first |
| leftOut | output | 24 | Left sample, MSB-aligned |
| rightOut | output | 24 | Right sample, MSB-aligned |
| sampleValid | output | 1 | One-cycle strobe for a new sample pair |
| powerDown | output | 1 | Decoded power-down status |
| deemphSel | output | 2 | Decoded de-emphasis selector |
| cfgError | output | 1 | Unsupported format or width selected |

## Verification
The assertions assume that bit-clock rises are several system clocks apart, so that two captures can never fall in consecutive cycles. They also assume that word clock and data are stable around every bit-clock rise. The stimulus meets both assumptions: it drives a bit clock of eight system periods and changes the word clock and data only half a bit period away from the rising edge, at times that never coincide with a system clock edge. It also changes the control word only while the link is idle, so each new setting starts from a restarted framing state.

// File: rtl/aurx_pkg.sv
package aurx_pkg;

  localparam logic [2:0] FMT_I2S = 3'b000;
  localparam logic [2:0] FMT_RJ  = 3'b001;
  localparam logic [2:0] FMT_DSP = 3'b010;
  localparam logic [2:0] FMT_LJ  = 3'b011;

  localparam int LEN_BITS = 6;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic                shiftEn;   // a new serial bit is present
    logic                takeLeft;  // latch left sample this cycle
    logic                takeRight; // latch right sample and publish pair
    logic                useHist;   // take word from history (excludes current bit)
    logic                clear;     // idle: zero all state
    logic [LEN_BITS-1:0] wordLen;   // active sample length in bits
  } rxStrobes_t;

endpackage

// File: rtl/aurx_sync.sv
module aurx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bclkIn,
  input  logic wclkIn,
  input  logic sdIn,
  output logic bitRise,
  output logic wclkS,
  output logic sdS
);

  logic [STAGES-1:0] bChain, wChain, dChain;
  logic              bPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bChain <= '0;
      wChain <= '0;
      dChain <= '0;
      bPrev  <= 1'b0;
    end else begin
      bChain <= {bChain[STAGES-2:0], bclkIn};
      wChain <= {wChain[STAGES-2:0], wclkIn};
      dChain <= {dChain[STAGES-2:0], sdIn};
      bPrev  <= bChain[STAGES-1];
    end
  end

  assign bitRise = bChain[STAGES-1] & ~bPrev;
  assign wclkS   = wChain[STAGES-1];
  assign sdS     = dChain[STAGES-1];

endmodule

// File: rtl/aurx_ctrl.sv
module aurx_ctrl
  import aurx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] ctrlWord,
  input  logic        bitRise,
  input  logic        wclkS,
  output rxStrobes_t  strobes,
  output logic        powerDown,
  output logic [1:0]  deemphSel,
  output logic        cfgError
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0]          fmtCode;
  logic [1:0]          widCode;
  logic [4:0]          cfgReg;
  logic                cfgChange, run;
  logic [LEN_BITS-1:0] wordLen;
  logic                prevW, haveLeft, wEdge, restart;
  logic [CNT_W-1:0]    cnt, kNow, lenK, len2K;
  logic                capL, capR, hist;

  assign fmtCode   = ctrlWord[7:5];
  assign widCode   = ctrlWord[4:3];
  assign powerDown = ctrlWord[2];
  assign deemphSel = ctrlWord[9:8];
  assign cfgError  = fmtCode[2] | (widCode == 2'b11);
  assign cfgChange = ({fmtCode, widCode} != cfgReg);
  assign run       = ~powerDown & ~cfgError & ~cfgChange;

  always_comb begin
    case (widCode)
      2'b01:   wordLen = LEN_BITS'(20);
      2'b10:   wordLen = LEN_BITS'(16);
      default: wordLen = LEN_BITS'(24);
    endcase
  end

  assign lenK  = CNT_W'(wordLen);
  assign len2K = CNT_W'({wordLen, 1'b0});
  assign wEdge = wclkS ^ prevW;
  // DSP frames restart only on the rising sync pulse
  assign restart = (fmtCode == FMT_DSP) ? (wclkS & ~prevW) : wEdge;
  assign kNow    = restart ? '0 : ((cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1);

  always_comb begin
    capL = 1'b0;
    capR = 1'b0;
    hist = 1'b0;
    case (fmtCode)
      FMT_I2S: begin
        capL = (kNow == lenK) & ~wclkS;
        capR = (kNow == lenK) &  wclkS;
      end
      FMT_LJ: begin
        capL = (kNow == lenK - 1'b1) &  wclkS;
        capR = (kNow == lenK - 1'b1) & ~wclkS;
      end
      FMT_RJ: begin
        hist = 1'b1;
        capL = wEdge &  prevW;
        capR = wEdge & ~prevW;
      end
      FMT_DSP: begin
        capL = (kNow == lenK);
        capR = (kNow == len2K);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg   <= '0;
      prevW    <= 1'b0;
      cnt      <= CNT_MAX;
      haveLeft <= 1'b0;
    end else begin
      cfgReg <= {fmtCode, widCode};
      if (!run) begin
        prevW    <= 1'b0;
        cnt      <= CNT_MAX;
        haveLeft <= 1'b0;
      end else if (bitRise) begin
        prevW <= wclkS;
        cnt   <= kNow;
        if (capL)      haveLeft <= 1'b1;
        else if (capR) haveLeft <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.shiftEn   = run & bitRise;
    strobes.takeLeft  = run & bitRise & capL;
    strobes.takeRight = run & bitRise & capR & haveLeft;
    strobes.useHist   = hist;
    strobes.clear     = ~run;
    strobes.wordLen   = wordLen;
  end

endmodule

// File: rtl/aurx_datapath.sv
module aurx_datapath
  import aurx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  rxStrobes_t          strobes,
  input  logic                sdS,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid
);

  localparam int AMT_W = $clog2(SAMPLE_W + 1);

  logic [SAMPLE_W-1:0] shReg, shNext, src, aligned, pendL;
  logic [AMT_W-1:0]    shAmt;

  assign shNext  = {shReg[SAMPLE_W-2:0], sdS};
  assign src     = strobes.useHist ? shReg : shNext;
  assign shAmt   = AMT_W'(SAMPLE_W) - AMT_W'(strobes.wordLen);
  assign aligned = src << shAmt;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) begin
      shReg       <= '0;
      pendL       <= '0;
      leftOut     <= '0;
      rightOut    <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (strobes.shiftEn)  shReg <= shNext;
      if (strobes.takeLeft) pendL <= aligned;
      if (strobes.takeRight) begin
        leftOut     <= pendL;
        rightOut    <= aligned;
        sampleValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int SAMPLE_W    = 24,
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [15:0]         ctrlWord,
  input  logic                bclkIn,
  input  logic                wclkIn,
  input  logic                sdIn,
  output logic [SAMPLE_W-1:0] leftOut,
  output logic [SAMPLE_W-1:0] rightOut,
  output logic                sampleValid,
  output logic                powerDown,
  output logic [1:0]          deemphSel,
  output logic                cfgError
);

  aurx_pkg::rxStrobes_t strobes;
  logic bitRise, wclkS, sdS;

  aurx_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .wclkIn(wclkIn), .sdIn(sdIn),
    .bitRise(bitRise), .wclkS(wclkS), .sdS(sdS)
  );

  aurx_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .bitRise(bitRise),
    .wclkS(wclkS), .strobes(strobes), .powerDown(powerDown),
    .deemphSel(deemphSel), .cfgError(cfgError)
  );

  aurx_datapath #(.SAMPLE_W(SAMPLE_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdS(sdS),
    .leftOut(leftOut), .rightOut(rightOut), .sampleValid(sampleValid)
  );

endmodule

// File: rtl/aurx_checker.sv
module aurx_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic [15:0]         ctrlWord,
  input logic [SAMPLE_W-1:0] leftOut,
  input logic [SAMPLE_W-1:0] rightOut,
  input logic                sampleValid,
  input logic                powerDown,
  input logic                cfgError
);

  logic [4:0] prevCfg;
  logic       cfgSteady;

  always_ff @(posedge clk) begin
    if (!rstN) prevCfg <= '0;
    else       prevCfg <= ctrlWord[7:3];
  end
  assign cfgSteady = (ctrlWord[7:3] == prevCfg);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && $past(!cfgError && !powerDown && cfgSteady))
      |-> ($stable(leftOut) && $stable(rightOut))); // R6

  AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |=> (!sampleValid && leftOut == '0 && rightOut == '0)); // R7

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> (!sampleValid && leftOut == '0 && rightOut == '0)); // R8

  AST_ALIGN_16: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ctrlWord[4:3] == 2'b10 && cfgSteady)
      |-> (leftOut[7:0] == 8'h00 && rightOut[7:0] == 8'h00)); // R5

  AST_ALIGN_20: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && ctrlWord[4:3] == 2'b01 && cfgSteady)
      |-> (leftOut[3:0] == 4'h0 && rightOut[3:0] == 4'h0)); // R5

endmodule

bind audio_serial_rx aurx_checker #(.SAMPLE_W(SAMPLE_W)) uChk (
  .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .leftOut(leftOut),
  .rightOut(rightOut), .sampleValid(sampleValid), .powerDown(powerDown),
  .cfgError(cfgError)
);

// File: tb/sim_audio_serial_rx.sv
`timescale 1ns/100ps
module sim_audio_serial_rx;

  logic        clk, rstN;
  logic [15:0] ctrlWord;
  logic        bclkIn, wclkIn, sdIn;
  logic [23:0] leftOut, rightOut;
  logic        sampleValid, powerDown, cfgError;
  logic [1:0]  deemphSel;

  audio_serial_rx u0 (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .bclkIn(bclkIn),
    .wclkIn(wclkIn), .sdIn(sdIn), .leftOut(leftOut), .rightOut(rightOut),
    .sampleValid(sampleValid), .powerDown(powerDown),
    .deemphSel(deemphSel), .cfgError(cfgError)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int          nCmp = 0, nBad = 0;
  string       curReq = "R11";
  bit          chkEn = 0, expIdle = 0, done = 0;
  logic [23:0] expL[$], expR[$];
  logic [23:0] lastL = '0, lastR = '0;

  task automatic report(input bit ok, input string req, input string what,
                        input logic [47:0] act, input logic [47:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the behavioural expectation
  always @(negedge clk) begin
    if (chkEn) begin
      if (expIdle) begin
        report(!sampleValid && leftOut == 0 && rightOut == 0, curReq,
               "idle outputs", {leftOut, rightOut}, 48'h0);
      end else if (sampleValid) begin
        if (expL.size() == 0) begin
          report(1'b0, curReq, "unexpected valid", {leftOut, rightOut}, 48'h0);
        end else begin
          logic [23:0] eL, eR;
          eL = expL.pop_front();
          eR = expR.pop_front();
          report(leftOut == eL && rightOut == eR, curReq, "sample pair",
                 {leftOut, rightOut}, {eL, eR});
          lastL = eL;
          lastR = eR;
        end
      end else begin
        report(leftOut == lastL && rightOut == lastR, curReq, "held pair",
               {leftOut, rightOut}, {lastL, lastR});
      end
    end
  end

  task automatic setCtrl(input logic [15:0] w, input bit idle);
    chkEn = 0;
    ctrlWord = w;
    repeat (3) @(posedge clk);
    #1;
    lastL = '0;
    lastR = '0;
    expIdle = idle;
    chkEn = 1;
  endtask

  task automatic putBit(input logic w, input logic d);
    wclkIn = w;
    sdIn   = d;
    #20 bclkIn = 1'b1;
    #20 bclkIn = 1'b0;
  endtask

  // pat: 0 I2S, 1 RJ, 2 DSP, 3 LJ
  task automatic sendBurst(input int pat, input int n, input int frames,
                           input bit expectOut);
    logic idleLvl;
    idleLvl = (pat == 0);
    putBit(idleLvl, 1'($urandom));
    putBit(idleLvl, 1'($urandom));
    for (int f = 0; f < frames; f++) begin
      logic [23:0] vL, vR;
      vL = 24'($urandom) & 24'((1 << n) - 1);
      vR = 24'($urandom) & 24'((1 << n) - 1);
      if (expectOut) begin
        expL.push_back(vL << (24 - n));
        expR.push_back(vR << (24 - n));
      end
      for (int i = 0; i < 64; i++) begin
        logic w, d;
        logic [23:0] v;
        int j;
        j = i % 32;
        d = 1'($urandom);
        case (pat)
          0: begin
            w = (i >= 32);
            v = w ? vR : vL;
            if (j >= 1 && j <= n) d = v[n - j];
          end
          3: begin
            w = (i < 32);
            v = w ? vL : vR;
            if (j < n) d = v[n - 1 - j];
          end
          1: begin
            w = (i < 32);
            v = w ? vL : vR;
            if (j >= 32 - n) d = v[31 - j];
          end
          default: begin
            w = (i == 0);
            if (i >= 1 && i <= n) d = vL[n - i];
            else if (i > n && i <= 2 * n) d = vR[2 * n - i];
          end
        endcase
        putBit(w, d);
      end
    end
    if (pat == 1) putBit(1'b1, 1'($urandom));
    else          putBit(idleLvl, 1'($urandom));
    repeat (12) @(posedge clk);
    #1;
    report(expL.size() == 0, curReq, "all frames published",
           48'(expL.size()), 48'h0);
    expL.delete();
    expR.delete();
  endtask

  function automatic logic [15:0] mk(input logic [2:0] fmt, input logic [1:0] wid);
    return {8'h00, fmt, wid, 3'b000};
  endfunction

  initial begin
    #(150000 * 5);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ctrlWord = mk(3'b011, 2'b00);
    bclkIn = 1'b0; wclkIn = 1'b0; sdIn = 1'b0;
    #1;
    repeat (6) @(posedge clk);
    #1;
    report(!sampleValid && leftOut == 0 && rightOut == 0, "R11",
           "reset state", {leftOut, rightOut}, 48'h0);
    rstN = 1'b1;

    curReq = "R1"; setCtrl(mk(3'b000, 2'b00), 0); sendBurst(0, 24, 4, 1);
    curReq = "R1"; setCtrl(mk(3'b000, 2'b10), 0); sendBurst(0, 16, 3, 1);
    curReq = "R2"; setCtrl(mk(3'b011, 2'b01), 0); sendBurst(3, 20, 4, 1);
    curReq = "R2"; setCtrl(mk(3'b011, 2'b00), 0); sendBurst(3, 24, 3, 1);
    curReq = "R3"; setCtrl(mk(3'b001, 2'b10), 0); sendBurst(1, 16, 4, 1);
    curReq = "R3"; setCtrl(mk(3'b001, 2'b00), 0); sendBurst(1, 24, 3, 1);
    curReq = "R4"; setCtrl(mk(3'b010, 2'b00), 0); sendBurst(2, 24, 4, 1);
    curReq = "R4"; setCtrl(mk(3'b010, 2'b10), 0); sendBurst(2, 16, 3, 1);
    curReq = "R5"; setCtrl(mk(3'b010, 2'b01), 0); sendBurst(2, 20, 3, 1);

    // R10: upper bits set, samples unchanged
    curReq = "R10"; setCtrl(16'hAC00 | mk(3'b011, 2'b10), 0); sendBurst(3, 16, 3, 1);
    curReq = "R10"; setCtrl(16'h5400 | mk(3'b001, 2'b01), 0); sendBurst(1, 20, 3, 1);

    // R9: de-emphasis field
    for (int d = 0; d < 4; d++) begin
      curReq = "R9";
      setCtrl(mk(3'b011, 2'b00) | 16'(d << 8), 0);
      report(deemphSel == 2'(d), "R9", "deemphSel", 48'(deemphSel), 48'(d));
    end

    // R7: power-down
    curReq = "R7"; setCtrl(mk(3'b011, 2'b00) | 16'h0004, 1);
    report(powerDown == 1'b1, "R7", "powerDown", 48'(powerDown), 48'h1);
    sendBurst(3, 24, 2, 0);

    // R8: unsupported formats and reserved width
    curReq = "R8"; setCtrl(mk(3'b100, 2'b00), 1);
    report(cfgError == 1'b1, "R8", "cfgError fmt 100", 48'(cfgError), 48'h1);
    sendBurst(3, 24, 2, 0);
    curReq = "R8"; setCtrl(mk(3'b110, 2'b00), 1);
    report(cfgError == 1'b1, "R8", "cfgError fmt 110", 48'(cfgError), 48'h1);
    curReq = "R8"; setCtrl(mk(3'b111, 2'b01), 1);
    report(cfgError == 1'b1, "R8", "cfgError fmt 111", 48'(cfgError), 48'h1);
    curReq = "R8"; setCtrl(mk(3'b011, 2'b11), 1);
    report(cfgError == 1'b1, "R8", "cfgError width 11", 48'(cfgError), 48'h1);
    sendBurst(3, 24, 2, 0);

    // R12: after a setting change, outputs cleared then resume
    curReq = "R12"; setCtrl(mk(3'b011, 2'b00), 0);
    report(cfgError == 1'b0 && powerDown == 1'b0, "R12", "status clear",
           48'({cfgError, powerDown}), 48'h0);
    sendBurst(3, 24, 2, 1);
    curReq = "R12"; setCtrl(mk(3'b000, 2'b01), 0);
    report(leftOut == 0 && rightOut == 0, "R12", "cleared on change",
           {leftOut, rightOut}, 48'h0);
    sendBurst(0, 20, 2, 1);

    chkEn = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule